// File: doc/BRIEF.md
# Oversampling UART Receiver Front-End

This block turns a single asynchronous receive line into framed data words. A baud-rate generator outside the block supplies a one-cycle tick at sixteen times the baud rate. The block looks at the line once per tick, so every bit period spans sixteen samples. The line first passes through a two-flop synchronizer. While the receiver is idle, the first low sample it sees starts the check of a start bit. Samples 8, 9 and 10 of each bit period are then combined by a two-of-three majority. This vote confirms or rejects the start bit, and it also decides each data bit and the stop bit.

A finished frame holds eight data bits, or nine when the wide mode is selected. The word is written to a holding register together with a framing-error bit, and a receive-complete flag is raised. This flag can drive an interrupt. The host reads the word and pulses a read strobe, which clears the flag. If a second frame finishes before the host has read the first, the first word is kept and an overrun flag is set.

Top module: `uart_rx_frontend`

## Requirements
- R1: After reset the line is taken as high (idle), and `rx_done`, `rx_irq`, `frame_err`, `overrun` and `rx_data` are all 0.
- R2: While idle, a single low sample taken on a tick becomes sample 1 of a start bit. The sample count then advances by one on each tick.
- R3: If two or more of samples 8, 9 and 10 of the start bit are high, the start is dropped with no output change. The receiver then waits for the next low sample.
- R4: Each data bit and the stop bit take the two-of-three majority of samples 8, 9 and 10 of their own sixteen-sample period. A single disturbed sample among the three does not change the bit.
- R5: Data bits arrive least significant bit first. With `nine_bit_en` = 0 a frame carries 8 data bits and `rx_data[8]` reads 0. With `nine_bit_en` = 1 (sampled at the start bit) a frame carries 9 data bits.
- R6: The stop bit is decided at its sample 10. One clock later `rx_data` holds the word, `rx_done` is 1, and `rx_irq` equals `rx_done` gated by `irq_en`.
- R7: A one-cycle `rd_strobe` clears `rx_done`, `rx_irq` and `overrun` at the next clock edge.
- R8: A stop bit that votes low sets `frame_err` (1 = error), which is stored with that word. The receiver then starts no new frame until it has sampled the line high on a tick.
- R9: If a frame completes while `rx_done` is still 1 and no read is taking place, `overrun` is set and `rx_data` and `frame_err` keep the earlier word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_pin | input | 1 | Asynchronous serial receive line |
| tick16 | input | 1 | One-cycle pulse at sixteen times the baud rate |
| nine_bit_en | input | 1 | 1 selects 9 data bits per frame |
| irq_en | input | 1 | Enables the receive interrupt |
| rd_strobe | input | 1 | Host read pulse that clears the flags |
| rx_data | output | 9 | Received word, LSB-aligned |
| rx_done | output | 1 | Receive-complete flag |
| rx_irq | output | 1 | Receive interrupt request |
| frame_err | output | 1 | Stop bit was sampled low for this word |
| overrun | output | 1 | A frame was lost because the word had not been read |

## Verification
A change on `rx_pin` reaches the sampling logic two clocks later. The bench places its ticks four clocks apart and changes the line just after a tick, so the change is sampled at the next tick. Sample numbers are therefore exact, which lets the bench place a spike or a one-sample disturbance on a chosen sample. Results are due one clock after the stop bit's sample-10 tick, and a read clears the flags one clock after the strobe edge. The monitor acts on the rising edge of `rx_done`, checks the flags at the falling clock edge that follows the strobe, and flags any frame that reaches the monitor without a queued expectation.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_WAIT_HIGH
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] q;

  always_ff @(posedge clk) begin
    if (rst) q <= '1;
    else     q <= {q[STAGES-2:0], din};
  end

  assign dout = q[STAGES-1];
endmodule

// File: rtl/rx_sample_ctr.sv
module rx_sample_ctr #(
  parameter int OSR = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic line,
  input  logic active,
  input  logic restart,
  output logic vote_valid,
  output logic vote,
  output logic bit_end
);
  import uart_rx_pkg::*;

  localparam int CNT_W    = $clog2(OSR + 1);
  localparam int VOTE_MID = OSR / 2 + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] nxt;
  logic             v_lo_q, v_mid_q;
  logic             step;

  assign step = tick && active;
  assign nxt  = cnt_q + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      v_lo_q  <= 1'b1;
      v_mid_q <= 1'b1;
    end else if (restart) begin
      cnt_q   <= CNT_W'(1);
      v_lo_q  <= 1'b1;
      v_mid_q <= 1'b1;
    end else if (step) begin
      cnt_q <= (nxt == CNT_W'(OSR)) ? '0 : nxt;
      if (nxt == CNT_W'(VOTE_MID - 1)) v_lo_q  <= line;
      if (nxt == CNT_W'(VOTE_MID))     v_mid_q <= line;
    end
  end

  assign vote_valid = step && (nxt == CNT_W'(VOTE_MID + 1));
  assign vote       = maj3(v_lo_q, v_mid_q, line);
  assign bit_end    = step && (nxt == CNT_W'(OSR));

  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(OSR)) else $error("sample count out of range"); // R2

endmodule

// File: rtl/rx_frame_ctrl.sv
module rx_frame_ctrl #(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic                line,
  input  logic                nine_bit_en,
  input  logic                vote_valid,
  input  logic                vote,
  input  logic                bit_end,
  output logic                active,
  output logic                restart,
  output logic                frame_done,
  output logic [DATA_MAX-1:0] frame_data,
  output logic                frame_ferr
);
  import uart_rx_pkg::*;

  localparam int IDX_W = $clog2(DATA_MAX);

  rx_state_e            state_q;
  logic [DATA_MAX-1:0]  sh_q;
  logic [IDX_W-1:0]     idx_q;
  logic                 wide_q;
  logic [IDX_W-1:0]     last_idx;

  assign last_idx = wide_q ? IDX_W'(DATA_MAX - 1) : IDX_W'(DATA_MAX - 2);
  assign active   = (state_q == ST_START) || (state_q == ST_DATA) || (state_q == ST_STOP);
  assign restart  = (state_q == ST_IDLE) && tick && !line;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      sh_q       <= '0;
      idx_q      <= '0;
      wide_q     <= 1'b0;
      frame_done <= 1'b0;
      frame_data <= '0;
      frame_ferr <= 1'b0;
    end else begin
      frame_done <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (restart) begin
            state_q <= ST_START;
            wide_q  <= nine_bit_en;
            sh_q    <= '0;
          end
        end
        ST_START: begin
          if (vote_valid && vote) begin
            state_q <= ST_IDLE;
          end else if (bit_end) begin
            state_q <= ST_DATA;
            idx_q   <= '0;
          end
        end
        ST_DATA: begin
          if (vote_valid) sh_q <= {vote, sh_q[DATA_MAX-1:1]};
          if (bit_end) begin
            if (idx_q == last_idx) state_q <= ST_STOP;
            else                   idx_q   <= idx_q + IDX_W'(1);
          end
        end
        ST_STOP: begin
          if (vote_valid) begin
            frame_done <= 1'b1;
            frame_data <= wide_q ? sh_q : (sh_q >> 1);
            frame_ferr <= !vote;
            state_q    <= vote ? ST_IDLE : ST_WAIT_HIGH;
          end
        end
        ST_WAIT_HIGH: begin
          if (tick && line) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  AST_START_REJECT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_START && vote_valid && vote) |=> (state_q == ST_IDLE))
    else $error("noisy start not rejected"); // R3

  AST_DONE_FROM_STOP: assert property (@(posedge clk) disable iff (rst)
    frame_done |-> ($past(state_q) == ST_STOP))
    else $error("frame completed outside stop bit"); // R6

  AST_WAIT_HIGH: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT_HIGH && !(tick && line)) |=> (state_q == ST_WAIT_HIGH))
    else $error("re-armed before line high"); // R8

endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int DATA_MAX = 9
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                frame_done,
  input  logic [DATA_MAX-1:0] frame_data,
  input  logic                frame_ferr,
  input  logic                rd_strobe,
  input  logic                irq_en,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_done,
  output logic                rx_irq,
  output logic                frame_err,
  output logic                overrun
);
  logic done_next;
  logic lose;

  assign lose = frame_done && rx_done && !rd_strobe;

  always_comb begin
    done_next = rx_done;
    if (rd_strobe)  done_next = 1'b0;
    if (frame_done) done_next = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_done   <= 1'b0;
      rx_irq    <= 1'b0;
      frame_err <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      rx_done <= done_next;
      rx_irq  <= done_next && irq_en;
      if (lose) begin
        overrun <= 1'b1;
      end else begin
        if (rd_strobe) overrun <= 1'b0;
        if (frame_done) begin
          rx_data   <= frame_data;
          frame_err <= frame_ferr;
        end
      end
    end
  end

  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_strobe && !frame_done) |=> (!rx_done && !overrun))
    else $error("read did not clear flags"); // R7

  AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (rst)
    lose |=> (overrun && $stable(rx_data)))
    else $error("overrun lost earlier word"); // R9

endmodule

// File: rtl/uart_rx_frontend.sv
module uart_rx_frontend #(
  parameter int OSR         = 16,
  parameter int DATA_MAX    = 9,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rx_pin,
  input  logic                tick16,
  input  logic                nine_bit_en,
  input  logic                irq_en,
  input  logic                rd_strobe,
  output logic [DATA_MAX-1:0] rx_data,
  output logic                rx_done,
  output logic                rx_irq,
  output logic                frame_err,
  output logic                overrun
);
  logic                line_s;
  logic                active, restart;
  logic                vote_valid, vote, bit_end;
  logic                frame_done, frame_ferr;
  logic [DATA_MAX-1:0] frame_data;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(rx_pin), .dout(line_s)
  );

  rx_sample_ctr #(.OSR(OSR)) u_ctr (
    .clk(clk), .rst(rst), .tick(tick16), .line(line_s),
    .active(active), .restart(restart),
    .vote_valid(vote_valid), .vote(vote), .bit_end(bit_end)
  );

  rx_frame_ctrl #(.DATA_MAX(DATA_MAX)) u_ctrl (
    .clk(clk), .rst(rst), .tick(tick16), .line(line_s),
    .nine_bit_en(nine_bit_en), .vote_valid(vote_valid), .vote(vote),
    .bit_end(bit_end), .active(active), .restart(restart),
    .frame_done(frame_done), .frame_data(frame_data), .frame_ferr(frame_ferr)
  );

  rx_hold_reg #(.DATA_MAX(DATA_MAX)) u_hold (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_data(frame_data),
    .frame_ferr(frame_ferr), .rd_strobe(rd_strobe), .irq_en(irq_en),
    .rx_data(rx_data), .rx_done(rx_done), .rx_irq(rx_irq),
    .frame_err(frame_err), .overrun(overrun)
  );

endmodule

// File: tb/uart_rx_frontend_bench.sv
module uart_rx_frontend_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rx_pin = 1'b1;
  logic       tick16 = 1'b0;
  logic       nine_bit_en = 1'b0;
  logic       irq_en = 1'b1;
  logic       rd_strobe = 1'b0;
  logic [8:0] rx_data;
  logic       rx_done, rx_irq, frame_err, overrun;

  int checks = 0;
  int errors = 0;
  bit auto_rd = 1'b1;
  bit done_prev = 1'b0;
  bit finished = 1'b0;

  typedef struct packed { logic [8:0] data; logic ferr; } exp_t;
  exp_t exp_q[$];

  always #2 clk = ~clk;

  uart_rx_frontend u_uart_rx_frontend (
    .clk(clk), .rst(rst), .rx_pin(rx_pin), .tick16(tick16),
    .nine_bit_en(nine_bit_en), .irq_en(irq_en), .rd_strobe(rd_strobe),
    .rx_data(rx_data), .rx_done(rx_done), .rx_irq(rx_irq),
    .frame_err(frame_err), .overrun(overrun)
  );

  initial begin : tick_gen
    int ph;
    ph = 0;
    forever begin
      @(negedge clk);
      tick16 = (ph == 0);
      ph = (ph + 1) % 4;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic wait_tick();
    do @(posedge clk); while (tick16 !== 1'b1);
    @(negedge clk);
  endtask

  task automatic hold_line(input logic v, input int n);
    rx_pin = v;
    for (int i = 0; i < n; i++) wait_tick();
  endtask

  task automatic send_bit(input logic v, input bit glitch);
    if (glitch) begin
      hold_line(v, 8);
      hold_line(~v, 1);
      hold_line(v, 7);
    end else begin
      hold_line(v, 16);
    end
  endtask

  task automatic send_frame(input logic [8:0] d, input int nbits, input logic stop_v,
                            input int glitch_bit, input bit expect_it);
    exp_t e;
    if (expect_it) begin
      e.data = (nbits == 9) ? d : {1'b0, d[7:0]};
      e.ferr = !stop_v;
      exp_q.push_back(e);
    end
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < nbits; i++) send_bit(d[i], glitch_bit == i);
    send_bit(stop_v, glitch_bit == nbits);
    hold_line(1'b1, 4);
  endtask

  // scoreboard monitor
  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      if (!rst && rx_done && !done_prev) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R3 unexpected frame", int'(rx_data), 0);
        end else begin
          e = exp_q.pop_front();
          chk(rx_data == e.data, "R5 data", int'(rx_data), int'(e.data));
          chk(frame_err == e.ferr, "R8 frame_err", int'(frame_err), int'(e.ferr));
          chk(rx_irq == irq_en, "R6 irq", int'(rx_irq), int'(irq_en));
          if (auto_rd) begin
            rd_strobe = 1'b1;
            @(negedge clk);
            rd_strobe = 1'b0;
            chk(!rx_done && !rx_irq, "R7 read clears", int'({rx_done, rx_irq}), 0);
          end
        end
      end
      done_prev = rx_done;
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    exp_t keep;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(rx_done == 0, "R1 rx_done", int'(rx_done), 0);
    chk(rx_irq == 0, "R1 rx_irq", int'(rx_irq), 0);
    chk(frame_err == 0, "R1 frame_err", int'(frame_err), 0);
    chk(overrun == 0, "R1 overrun", int'(overrun), 0);
    chk(rx_data == 0, "R1 rx_data", int'(rx_data), 0);
    rst = 1'b0;
    hold_line(1'b1, 8);

    // R2, R5: plain 8-bit frames
    send_frame(9'h0A5, 8, 1'b1, -1, 1'b1);
    send_frame(9'h000, 8, 1'b1, -1, 1'b1);
    send_frame(9'h0FF, 8, 1'b1, -1, 1'b1);

    // R3: spikes rejected (8 low samples, then 2 low samples)
    hold_line(1'b0, 8);
    hold_line(1'b1, 30);
    hold_line(1'b0, 2);
    hold_line(1'b1, 30);
    chk(rx_done == 0, "R3 spike ignored", int'(rx_done), 0);
    send_frame(9'h03C, 8, 1'b1, -1, 1'b1);

    // R4: single disturbed sample in a data bit and in the stop bit
    send_frame(9'h05A, 8, 1'b1, 3, 1'b1);
    send_frame(9'h0C3, 8, 1'b1, 8, 1'b1);

    // R5: nine-bit mode
    nine_bit_en = 1'b1;
    send_frame(9'h1C3, 9, 1'b1, -1, 1'b1);
    send_frame(9'h0F0, 9, 1'b1, -1, 1'b1);
    nine_bit_en = 1'b0;

    // R6: interrupt disabled
    irq_en = 1'b0;
    send_frame(9'h011, 8, 1'b1, -1, 1'b1);
    irq_en = 1'b1;

    // R8: framing error, line held low afterwards must not start a frame
    send_bit(1'b0, 1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'b1 ^ i[0], 1'b0);
    keep.data = 9'h055; keep.ferr = 1'b1;
    exp_q.push_back(keep);
    send_bit(1'b0, 1'b0);
    hold_line(1'b0, 40);
    hold_line(1'b1, 4);
    send_frame(9'h077, 8, 1'b1, -1, 1'b1);

    // R9: overrun keeps first word
    auto_rd = 1'b0;
    send_frame(9'h0AB, 8, 1'b1, -1, 1'b1);
    send_frame(9'h0CD, 8, 1'b1, -1, 1'b0);
    @(negedge clk);
    chk(overrun == 1, "R9 overrun set", int'(overrun), 1);
    chk(rx_data == 9'h0AB, "R9 data kept", int'(rx_data), 'hAB);
    chk(rx_done == 1, "R9 done held", int'(rx_done), 1);
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    chk(!rx_done && !overrun && !rx_irq, "R7 read clears overrun",
        int'({rx_done, overrun, rx_irq}), 0);
    auto_rd = 1'b1;
    send_frame(9'h0E1, 8, 1'b1, -1, 1'b1);

    hold_line(1'b1, 20);
    chk(exp_q.size() == 0, "R6 all frames delivered", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule